// File: doc/BRIEF.md
# Multi-Pattern Test Data Generator

This block supplies the expected data word for register and memory diagnostics. A caller picks one of eight pattern families, loads that family's starting value, and then pulses a single-cycle advance strobe each time it wants the next word. The current word is always present on a registered output. Comparison, addressing and the choice of when to advance all remain with the caller.

A memory test normally writes a whole address range and then reads it back. Before the write pass the caller pulses the snapshot strobe, which copies the complete generator state. Before the read pass it pulses restore. The generator then reproduces, word for word, the sequence that the writer produced. This holds for the pseudo-random family as well, whose state consists of a 16-bit running sum and a 3-bit table index in addition to the word.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, `data_out` is all zeros and the latched pattern is code 0.
- R2: A `load` pulse latches `pat_sel` and sets `data_out` on the next cycle to that pattern's seed. The seeds are: code 0 gives zero; code 1 gives all ones; code 2 gives only bit 0 set; code 3 gives all ones except bit 0; code 4 gives zero; code 5 gives zero; code 6 gives zero; code 7 gives `seed_in`. For code 4, load also clears the running sum and the index.
- R3: For codes 0 (all zeros) and 1 (all ones), an advance leaves `data_out` unchanged.
- R4: For codes 2 (walking one) and 3 (walking zero), an advance rotates the 36-bit word left by one, and bit 35 re-enters at bit 0.
- R5: For codes 5 (alternating zeros and ones) and 7 (seed and its complement), an advance replaces the word with its 36-bit bitwise complement.
- R6: For code 6 (sequential), an advance adds one modulo 2^36, so all ones is followed by zero.
- R7: For code 4 (pseudo-random), an advance first increments the 3-bit index. It then builds three 16-bit slices. For each slice, the increment at the current index is added to the running sum, the new sum becomes the slice, and the index is incremented again. Slice 0 fills bits 35:20, slice 1 fills bits 19:4, and the upper 4 bits of slice 2 fill bits 3:0. The running sum keeps the full 16 bits of slice 2.
- R8: The increment at index i is taken from the octal list 134134, 054206, 036711, 103625, 117253, 154737, 041344, 006712, at position i mod 8. After a load of code 4, the first advance therefore gives bits 35:20 = 054206 octal.
- R9: A `snap` pulse stores the word, the running sum and the index. A later `restore` pulse reloads all three, and the restored word appears on `data_out` on the next cycle. Advances that follow reproduce the sequence from the snapshot point.
- R10: When strobes coincide, `load` wins over `restore`, and `restore` wins over `advance`.
- R11: Changing `pat_sel` without a `load` has no effect, because advances follow the pattern latched at the last load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 3 | Pattern code sampled on load |
| seed_in | input | 36 | Seed used by pattern code 7 |
| load | input | 1 | Apply the seed for `pat_sel` |
| advance | input | 1 | Step to the next word |
| snap | input | 1 | Capture generator state |
| restore | input | 1 | Reload the captured state |
| data_out | output | 36 | Current expected word |

## Verification
The bench builds the block with its default 36-bit width and 16-bit slice size, because the slice layout of the random family is defined at that size. Every pattern code is loaded and advanced 40 times, which exceeds one full rotation of the walking patterns. With that configuration, the bench also reaches sequential wrap-around: it restores a near-all-ones snapshot while the sequential pattern is selected. It also exercises a random-sequence replay in which restore and advance are asserted together.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic [2:0] {
    PAT_ZERO  = 3'd0,
    PAT_ONE   = 3'd1,
    PAT_WALK1 = 3'd2,
    PAT_WALK0 = 3'd3,
    PAT_RAND  = 3'd4,
    PAT_ALTZO = 3'd5,
    PAT_SEQ   = 3'd6,
    PAT_ALTSD = 3'd7
  } pat_e;

  localparam int SLICE_W = 16;
  localparam int IDX_W   = 3;

  // additive increments for the random family, addressed modulo 8
  function automatic logic [SLICE_W-1:0] rand_incr(input logic [IDX_W-1:0] i);
    case (i)
      3'd0: rand_incr = 16'o134134;
      3'd1: rand_incr = 16'o054206;
      3'd2: rand_incr = 16'o036711;
      3'd3: rand_incr = 16'o103625;
      3'd4: rand_incr = 16'o117253;
      3'd5: rand_incr = 16'o154737;
      3'd6: rand_incr = 16'o041344;
      default: rand_incr = 16'o006712;
    endcase
  endfunction
endpackage

// File: rtl/tdg_rand_step.sv
module tdg_rand_step
  import tdg_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic [SLICE_W-1:0] sum_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [DATA_W-1:0]  word_o
);
  localparam int NSLICE = (DATA_W + SLICE_W - 1) / SLICE_W;
  localparam int CAT_W  = NSLICE * SLICE_W;

  logic [CAT_W-1:0]   cat;
  logic [SLICE_W-1:0] acc;
  logic [IDX_W-1:0]   ix;

  always_comb begin
    ix  = IDX_W'(idx_i + 1'b1);
    acc = sum_i;
    cat = '0;
    for (int k = 0; k < NSLICE; k++) begin
      acc = acc + rand_incr(ix);
      cat[CAT_W-1-k*SLICE_W -: SLICE_W] = acc;
      ix  = IDX_W'(ix + 1'b1);
    end
    sum_o  = acc;
    idx_o  = ix;
    word_o = cat[CAT_W-1 -: DATA_W];
  end
endmodule

// File: rtl/tdg_pattern_step.sv
module tdg_pattern_step
  import tdg_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  pat_e              sel_pat,
  input  pat_e              cur_pat,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] seed_in,
  input  logic [DATA_W-1:0] rand_word,
  output logic [DATA_W-1:0] seed_o,
  output logic [DATA_W-1:0] next_o
);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] LSB  = DATA_W'(1);

  always_comb begin
    case (sel_pat)
      PAT_ONE:   seed_o = ONES;
      PAT_WALK1: seed_o = LSB;
      PAT_WALK0: seed_o = ~LSB;
      PAT_ALTSD: seed_o = seed_in;
      default:   seed_o = '0;
    endcase
  end

  always_comb begin
    case (cur_pat)
      PAT_WALK1, PAT_WALK0: next_o = {word_i[DATA_W-2:0], word_i[DATA_W-1]};
      PAT_ALTZO, PAT_ALTSD: next_o = ~word_i;
      PAT_SEQ:              next_o = word_i + LSB;
      PAT_RAND:             next_o = rand_word;
      default:              next_o = word_i;
    endcase
  end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tdg_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        pat_sel,
  input  logic [DATA_W-1:0] seed_in,
  input  logic              load,
  input  logic              advance,
  input  logic              snap,
  input  logic              restore,
  output logic [DATA_W-1:0] data_out
);
  localparam logic [DATA_W-1:0] LSB = DATA_W'(1);

  pat_e               pat_q;
  logic [DATA_W-1:0]  word_q, snap_word;
  logic [SLICE_W-1:0] sum_q, snap_sum, sum_nx;
  logic [IDX_W-1:0]   idx_q, snap_idx, idx_nx;
  logic [DATA_W-1:0]  rand_word, seed_w, next_w;

  tdg_rand_step #(.DATA_W(DATA_W)) u_rand (
    .sum_i(sum_q), .idx_i(idx_q),
    .sum_o(sum_nx), .idx_o(idx_nx), .word_o(rand_word)
  );

  tdg_pattern_step #(.DATA_W(DATA_W)) u_step (
    .sel_pat(pat_e'(pat_sel)), .cur_pat(pat_q), .word_i(word_q),
    .seed_in(seed_in), .rand_word(rand_word),
    .seed_o(seed_w), .next_o(next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q     <= PAT_ZERO;
      word_q    <= '0;
      sum_q     <= '0;
      idx_q     <= '0;
      snap_word <= '0;
      snap_sum  <= '0;
      snap_idx  <= '0;
    end else begin
      if (snap) begin
        snap_word <= word_q;
        snap_sum  <= sum_q;
        snap_idx  <= idx_q;
      end
      if (load) begin
        pat_q  <= pat_e'(pat_sel);
        word_q <= seed_w;
        sum_q  <= '0;
        idx_q  <= '0;
      end else if (restore) begin
        word_q <= snap_word;
        sum_q  <= snap_sum;
        idx_q  <= snap_idx;
      end else if (advance) begin
        word_q <= next_w;
        if (pat_q == PAT_RAND) begin
          sum_q <= sum_nx;
          idx_q <= idx_nx;
        end
      end
    end
  end

  assign data_out = word_q;

  // R3
  hold_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !restore && (pat_q == PAT_ZERO || pat_q == PAT_ONE))
      |=> $stable(data_out));

  // R4
  walk_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !restore && (pat_q == PAT_WALK1 || pat_q == PAT_WALK0))
      |=> data_out == {$past(data_out[DATA_W-2:0]), $past(data_out[DATA_W-1])});

  // R5
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !restore && (pat_q == PAT_ALTZO || pat_q == PAT_ALTSD))
      |=> data_out == ~$past(data_out));

  // R6
  seq_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !restore && pat_q == PAT_SEQ)
      |=> data_out == $past(data_out) + LSB);

  // R9
  restore_word_chk: assert property (@(posedge clk) disable iff (rst)
    (restore && !load) |=> data_out == $past(snap_word));

  // R10
  restore_over_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (restore && advance && !load) |=> sum_q == $past(snap_sum) && idx_q == $past(snap_idx));
endmodule

// File: tb/tb_test_pattern_gen.sv
module tb_test_pattern_gen;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   pat_sel = '0;
  logic [W-1:0] seed_in = '0;
  logic         load = 0, advance = 0, snap = 0, restore = 0;
  logic [W-1:0] data_out;

  int checks = 0, errors = 0;

  // reference model state
  logic [W-1:0] m_word;
  logic [15:0]  m_sum;
  int           m_idx;
  int           m_pat;

  always #2.5 clk = ~clk;

  test_pattern_gen #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .seed_in(seed_in),
    .load(load), .advance(advance), .snap(snap), .restore(restore),
    .data_out(data_out)
  );

  function automatic logic [15:0] tbl(input int i);
    logic [15:0] t [10];
    t = '{16'o134134, 16'o054206, 16'o036711, 16'o103625, 16'o117253,
          16'o154737, 16'o041344, 16'o006712, 16'o134134, 16'o054206};
    return t[i];
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] seed_of(input int p, input logic [W-1:0] s);
    case (p)
      1: return {W{1'b1}};
      2: return 36'h1;
      3: return {W{1'b1}} - 36'h1;
      7: return s;
      default: return '0;
    endcase
  endfunction

  task automatic model_adv();
    logic [15:0] s0, s1, s2;
    case (m_pat)
      2, 3: m_word = (m_word << 1) | (m_word >> (W - 1));
      5, 7: m_word = m_word ^ {W{1'b1}};
      6:    m_word = m_word + 36'd1;
      4: begin
        m_idx = (m_idx + 1) % 8;
        s0 = m_sum + tbl(m_idx);
        s1 = s0 + tbl(m_idx + 1);
        s2 = s1 + tbl(m_idx + 2);
        m_idx = m_idx + 3;
        m_sum = s2;
        m_word = {s0, s1, s2[15:12]};
      end
      default: ;
    endcase
  endtask

  // one clock: inputs set at negedge, outputs read at next negedge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input int p, input logic [W-1:0] s);
    pat_sel = 3'(p); seed_in = s; load = 1;
    tick(); load = 0;
    m_pat = p; m_word = seed_of(p, s); m_sum = '0; m_idx = 0;
  endtask

  task automatic do_adv();
    advance = 1; tick(); advance = 0;
    model_adv();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] sw; logic [15:0] ssum; int sidx;
    tick(); tick();
    check("R1 in reset", data_out, '0);
    rst = 0; tick();
    check("R1 after reset", data_out, '0);
    // R11: pattern 0 latched by reset, advance with other select stays zero
    pat_sel = 3'd1; do_adv(); m_pat = 0;
    check("R11 latched pattern 0", data_out, '0);

    for (int p = 0; p < 8; p++) begin
      do_load(p, 36'h9_A5C3_3C5A);
      check("R2 seed", data_out, m_word);
      for (int n = 0; n < 40; n++) begin
        do_adv();
        case (p)
          0, 1: check("R3 hold", data_out, m_word);
          2, 3: check("R4 rotate", data_out, m_word);
          4:    check("R7 random", data_out, m_word);
          5, 7: check("R5 complement", data_out, m_word);
          default: check("R6 increment", data_out, m_word);
        endcase
      end
    end

    // R8: first random slice literal
    do_load(4, '0); do_adv();
    check("R8 first slice", {20'h0, data_out[35:20]}, {20'h0, 16'o054206});

    // R11: select change without load has no effect on sequential
    do_load(6, '0); pat_sel = 3'd1;
    do_adv(); do_adv();
    check("R11 select ignored", data_out, 36'd2);

    // R9 / R10: random replay with restore+advance together
    do_load(4, '0); do_adv(); do_adv(); do_adv();
    snap = 1; tick(); snap = 0;
    sw = m_word; ssum = m_sum; sidx = m_idx;
    for (int n = 0; n < 5; n++) do_adv();
    restore = 1; advance = 1; tick(); restore = 0; advance = 0;
    m_word = sw; m_sum = ssum; m_idx = sidx;
    check("R10 restore over advance", data_out, m_word);
    for (int n = 0; n < 6; n++) begin
      do_adv();
      check("R9 replay", data_out, m_word);
    end

    // R6 wrap: snapshot of near-all-ones, restored under sequential
    do_load(3, '0);
    snap = 1; tick(); snap = 0;
    sw = m_word;
    do_load(6, '0);
    restore = 1; tick(); restore = 0; m_word = sw;
    check("R9 restore word", data_out, {W{1'b1}} - 36'h1);
    do_adv(); check("R6 to all ones", data_out, {W{1'b1}});
    do_adv(); check("R6 wrap", data_out, '0);

    // R10: load wins over restore
    pat_sel = 3'd1; load = 1; restore = 1; tick(); load = 0; restore = 0;
    check("R10 load over restore", data_out, {W{1'b1}});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule